// File: doc/BRIEF.md
# Address Decoder with Default Target

This block sits between one memory-mapped requester and a set of responders. Each responder owns a window in the address space. The window is defined by a base address and a power-of-two span, and both come from parameters. The block looks at every read or write and raises the select line of the one responder whose window contains the address. It passes command, address and write data through to that responder. It then returns that responder's stall indication and read data to the requester. The handshake is request / waitrequest / readdatavalid: a transfer is accepted on a rising edge where the request is high and waitrequest is low.

An address that falls in no window is not dropped. It goes to a fallback responder, chosen by index at build time. When the index is negative, the responder with the widest window becomes the fallback instead. The intended use is a small scratch memory that soaks up stray traffic so that real memories and peripherals are not corrupted.

A sticky flag and a saturating counter record accepted transfers that missed every window, so a test environment can look for stray traffic. Only one read may be in flight. While a read is in flight, any new request is stalled until its data returns.

Top module: `addr_decoder_dflt`

## Requirements
- R1: A request whose address lies in window i (base_i <= address < base_i + span_i) raises only select i in the same cycle. The default table maps responder 0 at 0x0 with span 0x10000, and responders 1..5 at 0x10000, 0x10010, 0x10020, 0x10030 and 0x10040, each with span 0x10.
- R2: At most one select is high in any cycle, and no select is high when neither read nor write is requested.
- R3: A request whose address lies in no window raises the select of the fallback responder given by DFLT_IDX (5 by default).
- R4: With DFLT_IDX negative, the fallback is the responder with the largest span (responder 0 in the default table).
- R5: The requester's waitrequest equals the selected responder's waitrequest while a request is present. Waitrequest from responders that are not selected has no effect.
- R6: Read-valid and read data are returned in the same cycle the targeted responder raises its read-valid. Read-valid from any other responder is not passed on.
- R7: While an accepted read awaits its data, any new request sees waitrequest high and raises no select.
- R8: The read and write strobes, the address and the write data are passed to the responders unchanged in the cycle of the request.
- R9: Each accepted transfer to an unmapped address sets the sticky miss flag and increments the miss counter, which saturates at all ones. Both show the new value in the cycle after the accepting edge.
- R10: After reset, no select is high, read-valid is low, and the miss flag and counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_read | input | 1 | Requester read strobe |
| m_write | input | 1 | Requester write strobe |
| m_addr | input | AW | Requester byte address |
| m_wdata | input | DW | Requester write data |
| m_waitreq | output | 1 | Stall back to requester |
| m_rdata | output | DW | Read data to requester |
| m_rvalid | output | 1 | Read data valid to requester |
| s_sel | output | NS | One-hot responder select |
| s_read | output | 1 | Read strobe to responders |
| s_write | output | 1 | Write strobe to responders |
| s_addr | output | AW | Address to responders |
| s_wdata | output | DW | Write data to responders |
| s_waitreq | input | NS | Per-responder stall |
| s_rdata | input | NS*DW | Per-responder read data, responder i in bits [i*DW +: DW] |
| s_rvalid | input | NS | Per-responder read valid |
| miss_seen | output | 1 | Sticky unmapped-access flag |
| miss_count | output | CNT_W | Saturating unmapped-access count |

## Verification
Selects, strobes and waitrequest are combinational. The bench drives each request on the falling edge and checks them 1 ns later in the same cycle. Read data is due in whatever cycle the bench's responder model raises read-valid, 1 to 3 cycles after the accepting edge, and is checked in that cycle. The cycles before it are used to verify that stray valids and new requests are held off. The miss flag and counter are registered, so they are checked on the falling edge that follows the accepting rising edge.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

  // Address arithmetic is done at a fixed 64-bit width; callers zero-extend.
  localparam int CALC_W = 64;

  // Address lies in the aligned power-of-two window at base.
  function automatic logic win_hit(input logic [CALC_W-1:0] addr,
                                   input logic [CALC_W-1:0] base,
                                   input logic [CALC_W-1:0] span);
    return ((addr & ~(span - 64'd1)) == base);
  endfunction

  // Two half-open ranges share at least one byte.
  function automatic logic windows_overlap(input logic [CALC_W-1:0] b0,
                                           input logic [CALC_W-1:0] s0,
                                           input logic [CALC_W-1:0] b1,
                                           input logic [CALC_W-1:0] s1);
    return (b0 < b1 + s1) && (b1 < b0 + s0);
  endfunction

endpackage

// File: rtl/dec_match.sv
module dec_match
  import addr_dec_pkg::*;
#(
  parameter int NS = 6,
  parameter int AW = 32,
  parameter int DFLT_IDX = 5,
  parameter logic [NS-1:0][AW-1:0] BASES = '0,
  parameter logic [NS-1:0][AW-1:0] SPANS = '0
) (
  input  logic [AW-1:0] addr,
  output logic [NS-1:0] tgt,
  output logic          miss
);

  function automatic int widest_window();
    int best = 0;
    for (int i = 1; i < NS; i++)
      if (SPANS[i] > SPANS[best]) best = i;
    return best;
  endfunction

  localparam int FALLBACK = (DFLT_IDX >= 0) ? DFLT_IDX : widest_window();
  localparam logic [NS-1:0] FALLBACK_OH = {{(NS-1){1'b0}}, 1'b1} << FALLBACK;

  logic [NS-1:0] hit_vec;

  for (genvar gi = 0; gi < NS; gi++) begin : g_win
    assign hit_vec[gi] = win_hit(CALC_W'(addr), CALC_W'(BASES[gi]), CALC_W'(SPANS[gi]));
  end

  assign miss = ~|hit_vec;
  assign tgt  = miss ? FALLBACK_OH : hit_vec;

  // Build-time guards: windows disjoint, fallback index in range.
  initial begin
    for (int i = 0; i < NS; i++) begin
      for (int j = i + 1; j < NS; j++) begin
        p_no_overlap_r1: assert (!windows_overlap(CALC_W'(BASES[i]), CALC_W'(SPANS[i]),
                                                  CALC_W'(BASES[j]), CALC_W'(SPANS[j])))
          else $error("windows %0d and %0d overlap", i, j);
      end
    end
    p_fallback_range_r3: assert (FALLBACK < NS)
      else $error("fallback index %0d out of range", FALLBACK);
  end

endmodule

// File: rtl/dec_resp.sv
module dec_resp #(
  parameter int NS = 6,
  parameter int DW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_accept,
  input  logic [NS-1:0]    tgt,
  input  logic [NS-1:0]    s_rvalid,
  input  logic [NS*DW-1:0] s_rdata,
  output logic             pend,
  output logic             m_rvalid,
  output logic [DW-1:0]    m_rdata
);

  logic          pend_q;
  logic [NS-1:0] pend_tgt_q;
  logic          rv_hit;

  assign rv_hit   = pend_q & |(pend_tgt_q & s_rvalid);
  assign pend     = pend_q;
  assign m_rvalid = rv_hit;

  always_comb begin
    m_rdata = '0;
    for (int i = 0; i < NS; i++)
      if (pend_tgt_q[i]) m_rdata = m_rdata | s_rdata[i*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_tgt_q <= '0;
    end else if (rd_accept) begin
      pend_q     <= 1'b1;
      pend_tgt_q <= tgt;
    end else if (rv_hit) begin
      pend_q     <= 1'b0;
    end
  end

  // R7: the top never accepts a read while another is in flight.
  p_single_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |-> !pend_q);

  // R6: the target register holds one responder while waiting.
  p_pend_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> $onehot0(pend_tgt_q) && (pend_tgt_q != '0));

endmodule

// File: rtl/dec_miss_log.sv
module dec_miss_log #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_accept,
  input  logic             miss,
  output logic             miss_seen,
  output logic [CNT_W-1:0] miss_count
);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + CNT_W'(1);
  endfunction

  logic miss_evt;
  assign miss_evt = xfer_accept & miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_seen  <= 1'b0;
      miss_count <= '0;
    end else if (miss_evt) begin
      miss_seen  <= 1'b1;
      miss_count <= sat_inc(miss_count);
    end
  end

  p_seen_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miss_seen |=> miss_seen);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + CNT_W'(1)));

  p_count_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != '0) |-> miss_seen);

endmodule

// File: rtl/addr_decoder_dflt.sv
module addr_decoder_dflt #(
  parameter int NS = 6,
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CNT_W = 8,
  parameter int DFLT_IDX = 5,
  parameter logic [NS-1:0][AW-1:0] BASES = {32'h0001_0040, 32'h0001_0030, 32'h0001_0020,
                                            32'h0001_0010, 32'h0001_0000, 32'h0000_0000},
  parameter logic [NS-1:0][AW-1:0] SPANS = {32'h0000_0010, 32'h0000_0010, 32'h0000_0010,
                                            32'h0000_0010, 32'h0000_0010, 32'h0001_0000}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_read,
  input  logic             m_write,
  input  logic [AW-1:0]    m_addr,
  input  logic [DW-1:0]    m_wdata,
  output logic             m_waitreq,
  output logic [DW-1:0]    m_rdata,
  output logic             m_rvalid,
  output logic [NS-1:0]    s_sel,
  output logic             s_read,
  output logic             s_write,
  output logic [AW-1:0]    s_addr,
  output logic [DW-1:0]    s_wdata,
  input  logic [NS-1:0]    s_waitreq,
  input  logic [NS*DW-1:0] s_rdata,
  input  logic [NS-1:0]    s_rvalid,
  output logic             miss_seen,
  output logic [CNT_W-1:0] miss_count
);

  logic [NS-1:0] tgt;
  logic          miss;
  logic          pend;
  logic          req;
  logic          go;
  logic          sel_wait;
  logic          xfer_accept;
  logic          rd_accept;

  dec_match #(
    .NS(NS), .AW(AW), .DFLT_IDX(DFLT_IDX), .BASES(BASES), .SPANS(SPANS)
  ) u_match (
    .addr (m_addr),
    .tgt  (tgt),
    .miss (miss)
  );

  assign req         = m_read | m_write;
  assign go          = req & ~pend;
  assign sel_wait    = |(tgt & s_waitreq);
  assign m_waitreq   = req & (pend | sel_wait);
  assign xfer_accept = go & ~sel_wait;
  assign rd_accept   = xfer_accept & m_read;

  assign s_sel   = go ? tgt : '0;
  assign s_read  = m_read & go;
  assign s_write = m_write & go;
  assign s_addr  = m_addr;
  assign s_wdata = m_wdata;

  dec_resp #(.NS(NS), .DW(DW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_accept (rd_accept),
    .tgt       (tgt),
    .s_rvalid  (s_rvalid),
    .s_rdata   (s_rdata),
    .pend      (pend),
    .m_rvalid  (m_rvalid),
    .m_rdata   (m_rdata)
  );

  dec_miss_log #(.CNT_W(CNT_W)) u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_accept (xfer_accept),
    .miss        (miss),
    .miss_seen   (miss_seen),
    .miss_count  (miss_count)
  );

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_sel));

  p_idle_nosel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_read || m_write) |-> (s_sel == '0) && !m_waitreq);

  p_accept_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_read || m_write) && !m_waitreq) |-> ($countones(s_sel) == 1));

  p_stall_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && (m_read || m_write)) |-> m_waitreq && (s_sel == '0));

  p_miss_fallback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !pend && (m_read || m_write)) |-> (s_sel == tgt) && !$onehot0(~tgt));

endmodule

// File: tb/addr_decoder_dflt_tb_top.sv
module addr_decoder_dflt_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NS = 6;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int CNT_W = 4;
  localparam int FB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             m_read = 0, m_write = 0;
  logic [AW-1:0]    m_addr = '0;
  logic [DW-1:0]    m_wdata = '0;
  logic             m_waitreq, m_rvalid;
  logic [DW-1:0]    m_rdata;
  logic [NS-1:0]    s_sel;
  logic             s_read, s_write;
  logic [AW-1:0]    s_addr;
  logic [DW-1:0]    s_wdata;
  logic [NS-1:0]    s_waitreq = '0;
  logic [NS-1:0]    s_rvalid = '0;
  logic [DW-1:0]    tb_rdata [NS];
  logic [NS*DW-1:0] s_rdata;
  logic             miss_seen;
  logic [CNT_W-1:0] miss_count;

  always_comb
    for (int i = 0; i < NS; i++) s_rdata[i*DW +: DW] = tb_rdata[i];

  addr_decoder_dflt #(.CNT_W(CNT_W), .DFLT_IDX(FB)) dut_i (
    .clk(clk), .rst_n(rst_n), .m_read(m_read), .m_write(m_write), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_waitreq(m_waitreq), .m_rdata(m_rdata), .m_rvalid(m_rvalid),
    .s_sel(s_sel), .s_read(s_read), .s_write(s_write), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_waitreq(s_waitreq), .s_rdata(s_rdata), .s_rvalid(s_rvalid),
    .miss_seen(miss_seen), .miss_count(miss_count));

  // Second instance: fallback picked by widest window.
  logic          b_waitreq, b_rvalid, b_read, b_write, b_seen;
  logic [DW-1:0] b_rdata, b_wdata;
  logic [AW-1:0] b_addr;
  logic [NS-1:0] b_sel;
  logic [7:0]    b_count;

  addr_decoder_dflt #(.DFLT_IDX(-1)) dut_b (
    .clk(clk), .rst_n(rst_n), .m_read(m_read), .m_write(m_write), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_waitreq(b_waitreq), .m_rdata(b_rdata), .m_rvalid(b_rvalid),
    .s_sel(b_sel), .s_read(b_read), .s_write(b_write), .s_addr(b_addr), .s_wdata(b_wdata),
    .s_waitreq('0), .s_rdata('0), .s_rvalid('1),
    .miss_seen(b_seen), .miss_count(b_count));

  int n_cmp = 0;
  int n_bad = 0;
  int exp_miss = 0;

  function automatic logic [32:0] tb_base(int i);
    return (i == 0) ? 33'h0 : 33'h10000 + 33'(16 * (i - 1));
  endfunction
  function automatic logic [32:0] tb_span(int i);
    return (i == 0) ? 33'h10000 : 33'd16;
  endfunction
  function automatic int exp_tgt(logic [31:0] a, int fb);
    for (int i = 0; i < NS; i++)
      if ({1'b0, a} >= tb_base(i) && {1'b0, a} < tb_base(i) + tb_span(i)) return i;
    return fb;
  endfunction
  function automatic logic is_unmapped(logic [31:0] a);
    return exp_tgt(a, -1) < 0;
  endfunction
  function automatic logic [DW-1:0] resp_data(int i, logic [31:0] a);
    return (i == 4) ? 64'h0000_0000_DE10_DE10 : {32'hA500_0000 + 32'(i), a};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit is_rd, input logic [31:0] a, input int wmax, input int lat, input bit stray);
    int t, tb, w, other;
    logic [NS-1:0] rb;
    t  = exp_tgt(a, FB);
    tb = exp_tgt(a, 0);
    w  = $urandom_range(wmax, 0);
    @(negedge clk);
    m_read = is_rd; m_write = !is_rd; m_addr = a; m_wdata = {$urandom, $urandom};
    for (int c = 0; c <= w; c++) begin
      if (c > 0) @(negedge clk);
      rb = NS'($urandom);
      s_waitreq = (c < w) ? (rb | (NS'(1) << t)) : (rb & ~(NS'(1) << t));
      #1;
      if (c == 0) check(b_sel == (NS'(1) << tb), "R4 widest-window fallback select", 64'(b_sel), 64'(NS'(1) << tb));
      check(s_sel == (NS'(1) << t), is_unmapped(a) ? "R3 fallback select" : "R1 window select",
            64'(s_sel), 64'(NS'(1) << t));
      check(m_waitreq == (c < w), "R5 waitrequest follows selected", 64'(m_waitreq), 64'(c < w));
      check(s_read == is_rd && s_write == !is_rd && s_addr == a && s_wdata == m_wdata,
            "R8 command passthrough", {s_addr, 30'd0, s_read, s_write}, {a, 30'd0, is_rd, !is_rd});
    end
    @(negedge clk);
    m_read = 0; m_write = 0; s_waitreq = NS'($urandom);
    if (is_unmapped(a) && exp_miss < 15) exp_miss++;
    #1;
    check(s_sel == '0 && !m_waitreq, "R2 idle no select", 64'(s_sel), 64'(0));
    check(miss_count == CNT_W'(exp_miss) && miss_seen == (exp_miss > 0), "R9 miss log",
          {miss_seen, 59'd0, miss_count}, {(exp_miss > 0), 59'd0, CNT_W'(exp_miss)});
    if (is_rd) begin
      for (int k = 1; k <= lat; k++) begin
        if (k > 1) @(negedge clk);
        if (k < lat) begin
          other = (t + 1 + int'($urandom_range(NS - 2, 0))) % NS;
          s_rvalid = NS'(1) << other;
          tb_rdata[other] = {$urandom, $urandom};
          if (stray) begin m_write = 1; m_addr = 32'h10010; end
          #1;
          check(!m_rvalid, "R6 foreign read-valid ignored", 64'(m_rvalid), 64'(0));
          if (stray)
            check(m_waitreq && s_sel == '0, "R7 stall while read pending",
                  {63'(s_sel), m_waitreq}, 64'(1));
        end else begin
          m_write = 0;
          s_rvalid = NS'(1) << t;
          tb_rdata[t] = resp_data(t, a);
          #1;
          check(m_rvalid && m_rdata == resp_data(t, a), "R6 read data return",
                m_rvalid ? m_rdata : 64'hX, resp_data(t, a));
        end
      end
      @(negedge clk);
      s_rvalid = '0; m_write = 0;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7131));
    for (int i = 0; i < NS; i++) tb_rdata[i] = '0;
    repeat (3) @(negedge clk);
    check(s_sel == '0 && !m_rvalid && !miss_seen && miss_count == '0, "R10 reset state",
          {miss_seen, 53'd0, m_rvalid, miss_count, 6'(s_sel)}, 64'(0));
    rst_n = 1;
    @(negedge clk);
    check(!miss_seen && miss_count == '0, "R10 after release", 64'(miss_count), 64'(0));
    // Directed window edges and holes.
    xfer(1, 32'h0000_0000, 0, 1, 0);
    xfer(1, 32'h0000_FFFF, 2, 2, 1);
    xfer(0, 32'h0001_0000, 1, 1, 0);
    xfer(1, 32'h0001_001F, 0, 3, 1);
    xfer(1, 32'h0001_0030, 0, 2, 1);
    xfer(0, 32'h0001_004F, 0, 1, 0);
    xfer(0, 32'h0001_0050, 0, 1, 0);
    xfer(1, 32'hFFFF_FFFF, 3, 3, 1);
    xfer(1, 32'h0002_0000, 0, 1, 0);
    // Constrained random traffic.
    for (int n = 0; n < 250; n++) begin
      logic [31:0] a;
      a = ($urandom_range(1, 0) == 1) ? ($urandom % 32'h0001_0080) : $urandom;
      xfer(1'($urandom), a, 3, $urandom_range(3, 1), 1'($urandom));
    end
    // Saturation.
    for (int n = 0; n < 20; n++) xfer(0, 32'h0003_0000 + 32'(n), 0, 1, 0);
    check(miss_count == '1 && miss_seen, "R9 counter saturates", 64'(miss_count), 64'(15));
    finish_run();
  end

endmodule